// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block is the device side of a 16-bit NOR-style memory whose address and data share one bus, seen during synchronous burst reads. While chip enable is low and the address strobe `adv_n` is low, the engine captures a start word address from the bus on each rising clock edge. Once the strobe returns high it counts a programmable initial latency in clock edges. It then places one word per clock from its internal array on the bus, stepping the address in one of three orders.

A ready line tells the host when words are on the bus. Its active level is programmable. It can be asserted either with each word or one cycle ahead of the first word. The line and the data bus each come with an output-enable signal for the pad, so a released line is high impedance. A 16-bit configuration word is loaded through a dedicated write port. Writes that carry a reserved latency, burst-length or wrap code are refused and flagged, and the previous setting stays in force.

Top module: `burst_read_engine`

## Requirements
- R1: After reset the configuration reads 16'h2FC8: latency code 101, ready active high, ready aligned with data, wrap bit 1, continuous order. `cfg_error` is 0.
- R2: With latency code L in `cfg[13:11]` (001 to 111), the first word is valid on the (L+2)-th rising edge after the strobe is sampled high. The bus therefore holds it after L+1 such edges, and each following edge brings the next word.
- R3: `cfg[8]`=1 makes ready active exactly while words are on the bus. `cfg[8]`=0 makes it active from one cycle before the first word onward. During the rest of the latency it is at its inactive level.
- R4: `cfg[10]`=1 makes ready high when active. `cfg[10]`=0 makes it low when active.
- R5: `rdy_oe` is high exactly while `ce_n` is low. `ad_oe` is high only while a word is on the bus. A rising edge that samples `ce_n` high ends the burst.
- R6: `cfg[2:0]`=010 steps the address through its aligned 8-word block: the low 3 bits increment and wrap, and the upper bits hold.
- R7: `cfg[2:0]`=011 steps the address through its aligned 16-word block: the low 4 bits increment and wrap.
- R8: `cfg[2:0]`=000 steps the address by one, wrapping at the end of the 2^AW-word array.
- R9: A write with latency code 000, with `cfg[3]`=0, or with `cfg[2:0]` other than 000, 010 or 011 sets `cfg_error` and leaves the configuration unchanged. The next valid write clears `cfg_error`.
- R10: Reserved bits read back fixed whatever was written: bits 15, 14, 5 and 4 read 0; bits 9, 7 and 6 read 1.
- R11: The word stored at address a is a, zero-extended to 16 bits, XOR 16'hC3A5.
- R12: Sampling the strobe low during a burst restarts it from the new address with the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_q | output | 16 | Configuration in force |
| cfg_error | output | 1 | Last configuration write was refused |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| ad_in | input | 16 | Shared bus as seen by the device (address) |
| ad_out | output | 16 | Word driven onto the shared bus |
| ad_oe | output | 1 | Bus output enable |
| rdy | output | 1 | Ready level |
| rdy_oe | output | 1 | Ready output enable; low means high impedance |

## Verification
The hardest case to reach from the ports is the early-ready edge at the shortest latency. With code 001 and `cfg[8]`=0, ready must go active on the very first edge after the strobe rises, and a one-edge slip in the counter would go unseen at longer latencies. The vector table therefore pairs the extreme latency codes with both phase settings and both polarities. It starts the wrapped bursts near the end of their block and the continuous burst at the top of the array, so every wrap happens inside the observed window. Directed steps then restart a burst while words are flowing, and drop chip enable in mid-burst.

// File: rtl/burst_read_engine.sv
module burst_read_engine #(
  parameter int          AW   = 8,
  parameter logic [15:0] FILL = 16'hC3A5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_q,
  output logic        cfg_error,
  input  logic        ce_n,
  input  logic        adv_n,
  input  logic [15:0] ad_in,
  output logic [15:0] ad_out,
  output logic        ad_oe,
  output logic        rdy,
  output logic        rdy_oe
);

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA} st_t;

  st_t           st;
  logic [2:0]    lat_q, len_q;
  logic          pol_q, ph_q, early;
  logic [3:0]    cnt;
  logic [AW-1:0] addr, inc, nxt;
  logic [15:0]   dout;

  wire len_ok = (cfg_wdata[2:0] == 3'd0) || (cfg_wdata[2:0] == 3'd2) ||
                (cfg_wdata[2:0] == 3'd3);
  wire cfg_ok = (cfg_wdata[13:11] != 3'd0) && cfg_wdata[3] && len_ok;

  assign cfg_q = {2'b00, lat_q, pol_q, 1'b1, ph_q, 2'b11, 2'b00, 1'b1, len_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q     <= 3'd5;
      pol_q     <= 1'b1;
      ph_q      <= 1'b1;
      len_q     <= 3'd0;
      cfg_error <= 1'b0;
    end else if (cfg_we) begin
      cfg_error <= !cfg_ok;
      if (cfg_ok) begin
        lat_q <= cfg_wdata[13:11];
        pol_q <= cfg_wdata[10];
        ph_q  <= cfg_wdata[8];
        len_q <= cfg_wdata[2:0];
      end
    end
  end

  assign inc = addr + 1'b1;
  always_comb begin
    case (len_q)
      3'd2:    nxt = {addr[AW-1:3], inc[2:0]};
      3'd3:    nxt = {addr[AW-1:4], inc[3:0]};
      default: nxt = inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      addr  <= '0;
      early <= 1'b0;
      dout  <= '0;
    end else if (ce_n) begin
      st    <= S_IDLE;
      early <= 1'b0;
    end else if (!adv_n) begin
      st    <= S_LAT;
      cnt   <= '0;
      addr  <= ad_in[AW-1:0];
      early <= 1'b0;
    end else if (st == S_LAT) begin
      cnt <= cnt + 4'd1;
      if (cnt == {1'b0, lat_q} - 4'd1) early <= 1'b1;
      if (cnt == {1'b0, lat_q}) begin
        st   <= S_DATA;
        dout <= FILL ^ 16'(addr);
        addr <= nxt;
      end
    end else if (st == S_DATA) begin
      dout <= FILL ^ 16'(addr);
      addr <= nxt;
    end
  end

  wire rdy_act = ph_q ? (st == S_DATA) : early;
  assign rdy    = pol_q ? rdy_act : !rdy_act;
  assign rdy_oe = !ce_n;
  assign ad_oe  = !ce_n && (st == S_DATA);
  assign ad_out = dout;

  wire [15:0] cur_a = ad_out ^ FILL;

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_ok) |=> (cfg_error && $stable(cfg_q)));

  assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> ($past(adv_n) && $past(adv_n, 2)));

  assert_rdy_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ad_oe) && !$past(cfg_we) && !$past(cfg_we, 2)) |-> ($past(rdy_act) != ph_q));

  assert_wrap8_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(ad_oe) && len_q == 3'd2 && !$past(cfg_we) && !$past(cfg_we, 2)
     && !$past(cfg_we, 3))
    |-> (cur_a[AW-1:3] == $past(cur_a[AW-1:3]) && cur_a[2:0] == 3'($past(cur_a[2:0]) + 3'd1)));

  assert_linear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(ad_oe) && len_q == 3'd0 && !$past(cfg_we) && !$past(cfg_we, 2)
     && !$past(cfg_we, 3))
    |-> (cur_a[AW-1:0] == AW'($past(cur_a[AW-1:0]) + 1'b1)));

endmodule

// File: tb/tb_burst_read_engine.sv
module tb_burst_read_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, ce_n = 1'b1, adv_n = 1'b1;
  logic [15:0] cfg_wdata = '0, ad_in = '0;
  logic [15:0] cfg_q, ad_out;
  logic cfg_error, ad_oe, rdy, rdy_oe;

  burst_read_engine dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .cfg_error(cfg_error), .ce_n(ce_n), .adv_n(adv_n), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .rdy(rdy), .rdy_oe(rdy_oe));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;
  logic [2:0] lat, len;
  logic pol, ph;

  // fields: latency, polarity, phase, length, start address
  localparam logic [15:0] VEC [6] = '{
    {3'd5, 1'b1, 1'b1, 3'd0, 8'hFE},
    {3'd1, 1'b1, 1'b1, 3'd2, 8'h3D},
    {3'd7, 1'b0, 1'b0, 3'd3, 8'h2E},
    {3'd3, 1'b0, 1'b1, 3'd2, 8'h07},
    {3'd1, 1'b1, 1'b0, 3'd3, 8'hF5},
    {3'd6, 1'b1, 1'b0, 3'd0, 8'h10}
  };

  function automatic logic [15:0] mk(input logic [2:0] l, input logic p, input logic h,
                                     input logic [2:0] n);
    return {2'b00, l, p, 1'b1, h, 2'b11, 2'b00, 1'b1, n};
  endfunction

  function automatic logic [7:0] step(input logic [7:0] a, input logic [2:0] n);
    case (n)
      3'd2:    return {a[7:3], a[2:0] + 3'd1};
      3'd3:    return {a[7:4], a[3:0] + 4'd1};
      default: return a + 8'd1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic burst(input logic [7:0] a, input int nwords);
    logic [7:0] m = a;
    @(negedge clk);
    ce_n = 1'b0;
    adv_n = 1'b0;
    ad_in = {8'h00, a};
    @(negedge clk);
    adv_n = 1'b1;
    ad_in = '0;
    for (int k = 1; k <= int'(lat) + nwords; k++) begin
      logic act;
      @(negedge clk);
      act = ph ? (k >= int'(lat) + 1) : (k >= int'(lat));
      chk("R3 R4 rdy level", {31'd0, rdy}, {31'd0, pol ? act : !act});
      chk("R5 rdy_oe", {31'd0, rdy_oe}, 32'd1);
      chk("R2 R5 ad_oe", {31'd0, ad_oe}, {31'd0, k >= int'(lat) + 1});
      if (k >= int'(lat) + 1) begin
        case (len)
          3'd2:    chk("R6 R11 word", {16'd0, ad_out}, {16'd0, 16'hC3A5 ^ {8'h00, m}});
          3'd3:    chk("R7 R11 word", {16'd0, ad_out}, {16'd0, 16'hC3A5 ^ {8'h00, m}});
          default: chk("R8 R11 word", {16'd0, ad_out}, {16'd0, 16'hC3A5 ^ {8'h00, m}});
        endcase
        m = step(m, len);
      end
    end
  endtask

  task automatic end_burst();
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg", {16'd0, cfg_q}, 32'h2FC8);
    chk("R1 reset cfg_error", {31'd0, cfg_error}, 32'd0);
    chk("R5 idle rdy_oe", {31'd0, rdy_oe}, 32'd0);
    chk("R5 idle ad_oe", {31'd0, ad_oe}, 32'd0);

    lat = 3'd5; pol = 1'b1; ph = 1'b1; len = 3'd0;
    burst(8'h20, 4);
    end_burst();

    for (int i = 0; i < 6; i++) begin
      logic [15:0] v = VEC[i];
      lat = v[15:13]; pol = v[12]; ph = v[11]; len = v[10:8];
      wr_cfg(mk(lat, pol, ph, len));
      chk("R9 valid write", {31'd0, cfg_error}, 32'd0);
      chk("R10 readback", {16'd0, cfg_q}, {16'd0, mk(lat, pol, ph, len)});
      burst(v[7:0], 20);
      end_burst();
    end

    // R9: reserved codes refused; last vector stays in force
    wr_cfg(mk(3'd0, 1'b1, 1'b1, 3'd2));
    chk("R9 latency 000 flag", {31'd0, cfg_error}, 32'd1);
    chk("R9 latency 000 keep", {16'd0, cfg_q}, {16'd0, mk(lat, pol, ph, len)});
    wr_cfg(mk(3'd3, 1'b1, 1'b1, 3'd1));
    chk("R9 length 001 flag", {31'd0, cfg_error}, 32'd1);
    chk("R9 length 001 keep", {16'd0, cfg_q}, {16'd0, mk(lat, pol, ph, len)});
    wr_cfg(mk(3'd3, 1'b1, 1'b1, 3'd7));
    chk("R9 length 111 flag", {31'd0, cfg_error}, 32'd1);
    wr_cfg(mk(3'd3, 1'b1, 1'b1, 3'd2) & ~16'h0008);
    chk("R9 wrap bit 0 flag", {31'd0, cfg_error}, 32'd1);
    chk("R9 wrap bit 0 keep", {16'd0, cfg_q}, {16'd0, mk(lat, pol, ph, len)});
    burst(8'h44, 6);
    end_burst();

    // R10: reserved bits forced, fields taken
    wr_cfg(16'hFFFB);
    chk("R9 flag cleared", {31'd0, cfg_error}, 32'd0);
    chk("R10 reserved bits", {16'd0, cfg_q}, 32'h3FCB);
    lat = 3'd7; pol = 1'b1; ph = 1'b1; len = 3'd3;
    burst(8'h9A, 18);

    // R12: restart mid-burst
    lat = 3'd2; pol = 1'b0; ph = 1'b0; len = 3'd2;
    end_burst();
    wr_cfg(mk(lat, pol, ph, len));
    burst(8'h63, 5);
    burst(8'hB6, 10);

    // R5: chip enable drop ends the burst
    @(negedge clk);
    ce_n = 1'b1;
    #1;
    chk("R5 ce high rdy_oe", {31'd0, rdy_oe}, 32'd0);
    chk("R5 ce high ad_oe", {31'd0, ad_oe}, 32'd0);
    @(negedge clk);
    ce_n = 1'b0;
    @(negedge clk);
    chk("R5 ended ad_oe", {31'd0, ad_oe}, 32'd0);
    chk("R5 ended rdy_oe", {31'd0, rdy_oe}, 32'd1);
    chk("R3 R4 ended rdy inactive", {31'd0, rdy}, 32'd1);
    end_burst();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule